// File: doc/BRIEF.md
# Receive Guard Window Timer

This block times the receive side of one timeslot in a time-slotted, channel-hopping radio link. A slot-start strobe restarts a slot-relative time base that counts ticks of a 4 MHz timing grid. From three configuration values it derives a listening window: the transmit offset (when the sender's frame body begins), the preamble-plus-start-of-frame duration, and the guard time. The window is not centred on the transmit offset. Its centre sits half a preamble before that point, so the margin before the expected preamble start equals the margin after the expected end. The guard time is the preamble length plus twice the largest synchronization error that is tolerated. The window therefore opens at `tx_offset - preamble_len - m` and closes at `tx_offset + m`, where `m = (guard_len - preamble_len) / 2`.

The radio enable is raised while the window is open. When the radio reports a start-of-frame detection inside the window, the block records the tick at which it happened. It reports the signed synchronization error as that tick minus the transmit offset, and keeps the radio on until the end of the frame. When no detection arrives before the window closes, it drops the radio enable and raises a timeout flag. The MAC layer uses the error value to adjust its own timing. With the nominal figures (160 µs preamble, 10 µs maximum error) the guard shrinks to 180 µs, which is 720 ticks. The standard 2200 µs guard is simply a larger `guard_len` value.

Top module: `rx_guard_timer`

## Requirements
- R1: While `rst` is high, and on the clock after it, `radio_on`, `sfd_seen` and `rx_timeout` are 0 and `sync_err` is 0.
- R2: The elapsed tick count is 0 for the `CLK_PER_TICK` clocks after a slot-start edge and then advances by one every `CLK_PER_TICK` clocks, saturating at `SLOT_TICKS-1`. `radio_on` rises at the first edge where the count is at least OPEN = max(0, tx_offset − preamble_len − m), which is edge number `CLK_PER_TICK*OPEN+1` after the slot-start edge.
- R3: A `sfd_detect` sampled while listening sets `sfd_seen` and keeps `radio_on` high. It loads `sync_err` with the elapsed count minus `tx_offset` as a two's-complement value `TW+1` bits wide, negative for an early frame.
- R4: While listening, if the elapsed count is at least CLOSE = min(tx_offset + m, SLOT_TICKS−1) and `sfd_detect` is low, then at that edge `radio_on` falls, `rx_timeout` rises, and `sync_err` stays 0.
- R5: A `sfd_detect` sampled at the same edge that would close the window counts as a detection, not a timeout.
- R6: `sfd_detect` has no effect before the window opens, after a timeout, or once a frame has already been detected. In each case `sfd_seen`, `sync_err` and `radio_on` keep their values.
- R7: After a detection, `radio_on` stays high until `frame_end` is sampled high, and falls at that edge. `sfd_seen` and `sync_err` then hold until the next slot start.
- R8: The margin m is floor((guard_len − preamble_len)/2) when guard_len > preamble_len, and 0 otherwise.
- R9: `tx_offset`, `preamble_len` and `guard_len` are captured at the slot-start edge. Changes later in the slot do not move the window or the error reference.
- R10: A slot-start strobe in any state restarts the time base and, at that edge, clears `radio_on`, `sfd_seen`, `rx_timeout` and `sync_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_start | input | 1 | One-clock strobe marking the start of a receive timeslot |
| sfd_detect | input | 1 | Start-of-frame detected pulse from the radio |
| frame_end | input | 1 | Pulse marking the end of the received frame |
| tx_offset | input | TW | Expected frame-body start, in ticks after slot start |
| preamble_len | input | TW | Preamble plus start-of-frame duration, in ticks |
| guard_len | input | TW | Total guard time, in ticks |
| radio_on | output | 1 | Receiver enable |
| sfd_seen | output | 1 | A frame was detected in this slot |
| rx_timeout | output | 1 | The window closed with no detection |
| sync_err | output | TW+1 | Signed arrival error in ticks |

## Verification
The bench builds the block with `CLK_PER_TICK` = 3 and `SLOT_TICKS` = 600, keeping `TW` = 16. The short prescaler lets a stimulus land on the first, middle or last clock of any tick. The short slot lets a run reach the saturated end of the time base, where the close tick is clamped, within a couple of thousand clocks. With these sizes the bench can cover early and late arrivals, a detection exactly on the closing tick, a window that would open before slot start, and a restart in the middle of a frame, all inside one short run.

// File: rtl/rgw_pkg.sv
package rgw_pkg;

    typedef enum logic [2:0] {
        RG_IDLE   = 3'd0,
        RG_WAIT   = 3'd1,
        RG_LISTEN = 3'd2,
        RG_RX     = 3'd3,
        RG_DONE   = 3'd4
    } rg_state_e;

    typedef struct packed {
        int open_at;
        int close_at;
    } rg_bounds_t;

    // Symmetric margin around the preamble: half of the slack that the
    // guard leaves beyond the preamble itself, never negative.
    function automatic int rg_margin(input int pre, input int guard);
        int slack;
        slack = guard - pre;
        if (slack < 0)
            slack = 0;
        return slack / 2;
    endfunction

    function automatic rg_bounds_t rg_bounds(input int tx, input int pre,
                                             input int guard, input int last);
        rg_bounds_t b;
        int m;
        int lo;
        int hi;
        m  = rg_margin(pre, guard);
        lo = tx - pre - m;
        hi = tx + m;
        if (lo < 0)
            lo = 0;
        if (hi > last)
            hi = last;
        b.open_at  = lo;
        b.close_at = hi;
        return b;
    endfunction

    function automatic logic rg_listening(input rg_state_e s);
        return (s == RG_LISTEN) || (s == RG_RX);
    endfunction

endpackage

// File: rtl/rgw_tick_gen.sv
module rgw_tick_gen #(
    parameter int CLK_PER_TICK = 32,
    parameter int SLOT_TICKS   = 40000,
    parameter int TW           = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    output logic [TW-1:0] elapsed
);

    localparam int PW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [TW-1:0] LAST = TW'(SLOT_TICKS - 1);

    logic tick;

    generate
        if (CLK_PER_TICK == 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_presc
            localparam logic [PW-1:0] WRAP = PW'(CLK_PER_TICK - 1);
            logic [PW-1:0] phase;

            always_ff @(posedge clk) begin
                if (rst || restart)
                    phase <= '0;
                else if (phase == WRAP)
                    phase <= '0;
                else
                    phase <= phase + 1'b1;
            end

            assign tick = (phase == WRAP);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || restart)
            elapsed <= '0;
        else if (tick && (elapsed != LAST))
            elapsed <= elapsed + 1'b1;
    end

endmodule

// File: rtl/rgw_window_calc.sv
module rgw_window_calc
    import rgw_pkg::*;
#(
    parameter int SLOT_TICKS = 40000,
    parameter int TW         = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [TW-1:0] tx_offset,
    input  logic [TW-1:0] preamble_len,
    input  logic [TW-1:0] guard_len,
    output logic [TW-1:0] open_at,
    output logic [TW-1:0] close_at,
    output logic [TW-1:0] expect_at
);

    rg_bounds_t bnd;

    always_comb begin
        bnd = rg_bounds(int'(tx_offset), int'(preamble_len),
                        int'(guard_len), SLOT_TICKS - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_at   <= '0;
            close_at  <= '0;
            expect_at <= '0;
        end else if (capture) begin
            open_at   <= TW'(bnd.open_at);
            close_at  <= TW'(bnd.close_at);
            expect_at <= tx_offset;
        end
    end

endmodule

// File: rtl/rgw_listen_fsm.sv
module rgw_listen_fsm
    import rgw_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                slot_start,
    input  logic                sfd_detect,
    input  logic                frame_end,
    input  logic [TW-1:0]       elapsed,
    input  logic [TW-1:0]       open_at,
    input  logic [TW-1:0]       close_at,
    input  logic [TW-1:0]       expect_at,
    output logic                radio_on,
    output logic                sfd_seen,
    output logic                rx_timeout,
    output logic signed [TW:0]  sync_err
);

    rg_state_e state;
    logic signed [TW:0] arrival_err;

    assign arrival_err = $signed({1'b0, elapsed}) - $signed({1'b0, expect_at});

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RG_IDLE;
            sfd_seen   <= 1'b0;
            rx_timeout <= 1'b0;
            sync_err   <= '0;
        end else if (slot_start) begin
            state      <= RG_WAIT;
            sfd_seen   <= 1'b0;
            rx_timeout <= 1'b0;
            sync_err   <= '0;
        end else begin
            unique case (state)
                RG_WAIT: begin
                    if (elapsed >= open_at)
                        state <= RG_LISTEN;
                end
                RG_LISTEN: begin
                    if (sfd_detect) begin
                        state    <= RG_RX;
                        sfd_seen <= 1'b1;
                        sync_err <= arrival_err;
                    end else if (elapsed >= close_at) begin
                        state      <= RG_DONE;
                        rx_timeout <= 1'b1;
                    end
                end
                RG_RX: begin
                    if (frame_end)
                        state <= RG_DONE;
                end
                RG_IDLE, RG_DONE: begin
                    state <= state;
                end
                default: state <= RG_IDLE;
            endcase
        end
    end

    assign radio_on = rg_listening(state);

endmodule

// File: rtl/rx_guard_timer.sv
module rx_guard_timer #(
    parameter int CLK_PER_TICK = 32,
    parameter int SLOT_TICKS   = 40000,
    parameter int TW           = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slot_start,
    input  logic               sfd_detect,
    input  logic               frame_end,
    input  logic [TW-1:0]      tx_offset,
    input  logic [TW-1:0]      preamble_len,
    input  logic [TW-1:0]      guard_len,
    output logic               radio_on,
    output logic               sfd_seen,
    output logic               rx_timeout,
    output logic signed [TW:0] sync_err
);

    logic [TW-1:0] elapsed;
    logic [TW-1:0] open_at;
    logic [TW-1:0] close_at;
    logic [TW-1:0] expect_at;

    rgw_tick_gen #(
        .CLK_PER_TICK (CLK_PER_TICK),
        .SLOT_TICKS   (SLOT_TICKS),
        .TW           (TW)
    ) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (slot_start),
        .elapsed (elapsed)
    );

    rgw_window_calc #(
        .SLOT_TICKS (SLOT_TICKS),
        .TW         (TW)
    ) u_win (
        .clk          (clk),
        .rst          (rst),
        .capture      (slot_start),
        .tx_offset    (tx_offset),
        .preamble_len (preamble_len),
        .guard_len    (guard_len),
        .open_at      (open_at),
        .close_at     (close_at),
        .expect_at    (expect_at)
    );

    rgw_listen_fsm #(
        .TW (TW)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .slot_start (slot_start),
        .sfd_detect (sfd_detect),
        .frame_end  (frame_end),
        .elapsed    (elapsed),
        .open_at    (open_at),
        .close_at   (close_at),
        .expect_at  (expect_at),
        .radio_on   (radio_on),
        .sfd_seen   (sfd_seen),
        .rx_timeout (rx_timeout),
        .sync_err   (sync_err)
    );

endmodule

// File: rtl/rgw_checker.sv
module rgw_checker #(
    parameter int TW = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               slot_start,
    input logic               sfd_detect,
    input logic               frame_end,
    input logic               radio_on,
    input logic               sfd_seen,
    input logic               rx_timeout,
    input logic signed [TW:0] sync_err
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!radio_on && !sfd_seen && !rx_timeout && (sync_err == '0)));

    a_r4_timeout_radio_off: assert property (@(posedge clk) disable iff (rst)
        rx_timeout |-> !radio_on);

    a_r4_timeout_closes_window: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_timeout) |-> $fell(radio_on));

    a_r3_outcome_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(sfd_seen && rx_timeout));

    a_r3_detect_while_listening: assert property (@(posedge clk) disable iff (rst)
        (radio_on && !sfd_seen && sfd_detect && !slot_start) |=> (sfd_seen && radio_on));

    a_r6_detect_needs_radio: assert property (@(posedge clk) disable iff (rst)
        $rose(sfd_seen) |-> $past(radio_on));

    a_r7_error_held: assert property (@(posedge clk) disable iff (rst)
        (sfd_seen && !slot_start) |=> (sfd_seen && $stable(sync_err)));

    a_r7_frame_end_off: assert property (@(posedge clk) disable iff (rst)
        (sfd_seen && radio_on && frame_end && !slot_start) |=> !radio_on);

    a_r10_restart_clears: assert property (@(posedge clk) disable iff (rst)
        slot_start |=> (!radio_on && !sfd_seen && !rx_timeout && (sync_err == '0)));

endmodule

bind rx_guard_timer rgw_checker #(.TW(TW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .slot_start (slot_start),
    .sfd_detect (sfd_detect),
    .frame_end  (frame_end),
    .radio_on   (radio_on),
    .sfd_seen   (sfd_seen),
    .rx_timeout (rx_timeout),
    .sync_err   (sync_err)
);

// File: tb/tb_rx_guard_timer.sv
module tb_rx_guard_timer;

    localparam int CPT  = 3;
    localparam int SLOT = 600;
    localparam int TW   = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               slot_start = 1'b0;
    logic               sfd_detect = 1'b0;
    logic               frame_end = 1'b0;
    logic [TW-1:0]      tx_offset = '0;
    logic [TW-1:0]      preamble_len = '0;
    logic [TW-1:0]      guard_len = '0;
    logic               radio_on;
    logic               sfd_seen;
    logic               rx_timeout;
    logic signed [TW:0] sync_err;

    rx_guard_timer #(
        .CLK_PER_TICK (CPT),
        .SLOT_TICKS   (SLOT),
        .TW           (TW)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .slot_start   (slot_start),
        .sfd_detect   (sfd_detect),
        .frame_end    (frame_end),
        .tx_offset    (tx_offset),
        .preamble_len (preamble_len),
        .guard_len    (guard_len),
        .radio_on     (radio_on),
        .sfd_seen     (sfd_seen),
        .rx_timeout   (rx_timeout),
        .sync_err     (sync_err)
    );

    always #4 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int since = 0;
    int cycles = 0;
    bit finished = 0;

    // Behavioural reference: 0 idle, 1 waiting, 2 listening, 3 receiving, 4 closed
    int m_st = 0, m_ph = 0, m_el = 0, m_open = 0, m_close = 0, m_ref = 0;
    int m_seen = 0, m_to = 0, m_err = 0;

    always @(posedge clk) begin
        int now_el;
        int mg;
        now_el = m_el;
        if (rst) begin
            m_st = 0; m_ph = 0; m_el = 0; m_seen = 0; m_to = 0; m_err = 0;
            m_open = 0; m_close = 0; m_ref = 0;
        end else if (slot_start) begin
            mg = (int'(guard_len) > int'(preamble_len)) ?
                 (int'(guard_len) - int'(preamble_len)) / 2 : 0;
            m_open  = int'(tx_offset) - int'(preamble_len) - mg;
            if (m_open < 0) m_open = 0;
            m_close = int'(tx_offset) + mg;
            if (m_close > SLOT - 1) m_close = SLOT - 1;
            m_ref = int'(tx_offset);
            m_st = 1; m_ph = 0; m_el = 0; m_seen = 0; m_to = 0; m_err = 0;
        end else begin
            case (m_st)
                1: if (now_el >= m_open) m_st = 2;
                2: begin
                    if (sfd_detect) begin
                        m_st = 3; m_seen = 1; m_err = now_el - m_ref;
                    end else if (now_el >= m_close) begin
                        m_st = 4; m_to = 1;
                    end
                end
                3: if (frame_end) m_st = 4;
                default: ;
            endcase
            if (m_ph == CPT - 1) begin
                m_ph = 0;
                if (m_el < SLOT - 1) m_el = m_el + 1;
            end else begin
                m_ph = m_ph + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            tests++;
            if (radio_on !== ((m_st == 2) || (m_st == 3))) begin
                fails++;
                $display("FAIL R2 radio_on per-cycle: actual %0b expected %0b",
                         radio_on, (m_st == 2) || (m_st == 3));
            end
            tests++;
            if (sfd_seen !== m_seen[0]) begin
                fails++;
                $display("FAIL R3 sfd_seen per-cycle: actual %0b expected %0d", sfd_seen, m_seen);
            end
            tests++;
            if (rx_timeout !== m_to[0]) begin
                fails++;
                $display("FAIL R4 rx_timeout per-cycle: actual %0b expected %0d", rx_timeout, m_to);
            end
            tests++;
            if (int'(sync_err) != m_err) begin
                fails++;
                $display("FAIL R3 sync_err per-cycle: actual %0d expected %0d", int'(sync_err), m_err);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input int actual, input int expected);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic wait_until(input int t);
        while (since < t) begin
            @(negedge clk);
            since++;
        end
    endtask

    task automatic start_slot(input int tx, input int pre, input int grd);
        tx_offset    = TW'(tx);
        preamble_len = TW'(pre);
        guard_len    = TW'(grd);
        slot_start   = 1'b1;
        @(negedge clk);
        slot_start = 1'b0;
        since = 0;
    endtask

    // Drive a one-clock pulse that is sampled at edge number m after slot start
    task automatic sfd_at(input int m);
        wait_until(m - 1);
        sfd_detect = 1'b1;
        @(negedge clk);
        since++;
        sfd_detect = 1'b0;
    endtask

    task automatic fend_at(input int m);
        wait_until(m - 1);
        frame_end = 1'b1;
        @(negedge clk);
        since++;
        frame_end = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset radio_on", int'(radio_on), 0);
        check("R1 reset sfd_seen", int'(sfd_seen), 0);
        check("R1 reset rx_timeout", int'(rx_timeout), 0);
        check("R1 reset sync_err", int'(sync_err), 0);
        rst = 1'b0;
        @(negedge clk);

        // Late arrival: open 50, close 110, reference 100
        start_slot(100, 40, 60);
        sfd_at(31);
        check("R6 early sfd ignored", int'(sfd_seen), 0);
        wait_until(150);
        check("R2 closed before open tick", int'(radio_on), 0);
        wait_until(151);
        check("R2 open at tick 50", int'(radio_on), 1);
        sfd_at(3 * 104 + 1);
        check("R3 detect late seen", int'(sfd_seen), 1);
        check("R3 late error +4", int'(sync_err), 4);
        check("R3 radio held", int'(radio_on), 1);
        sfd_at(3 * 120 + 1);
        check("R6 second sfd ignored", int'(sync_err), 4);
        wait_until(400);
        check("R7 radio on before frame end", int'(radio_on), 1);
        fend_at(401);
        check("R7 radio off after frame end", int'(radio_on), 0);
        check("R7 error held", int'(sync_err), 4);
        check("R7 seen held", int'(sfd_seen), 1);

        // Timeout: nothing arrives
        start_slot(100, 40, 60);
        wait_until(330);
        check("R4 still listening at close-1", int'(rx_timeout), 0);
        wait_until(331);
        check("R4 timeout raised", int'(rx_timeout), 1);
        check("R4 radio dropped", int'(radio_on), 0);
        sfd_at(341);
        check("R6 sfd after timeout ignored", int'(sfd_seen), 0);

        // Early arrival, config changed mid-slot
        start_slot(100, 40, 60);
        tx_offset = TW'(300);
        guard_len = TW'(2);
        wait_until(151);
        check("R9 window unchanged", int'(radio_on), 1);
        sfd_at(3 * 52 + 1);
        check("R9 R3 early error -48", int'(sync_err), -48);

        // Detection on the closing tick
        tx_offset = TW'(100);
        guard_len = TW'(60);
        start_slot(100, 40, 60);
        sfd_at(3 * 110 + 1);
        check("R5 detect on close tick", int'(sfd_seen), 1);
        check("R5 no timeout", int'(rx_timeout), 0);
        check("R5 error +10", int'(sync_err), 10);

        // Restart during reception, guard below preamble
        start_slot(20, 40, 10);
        check("R10 restart radio off", int'(radio_on), 0);
        check("R10 restart seen cleared", int'(sfd_seen), 0);
        check("R10 restart error cleared", int'(sync_err), 0);
        wait_until(1);
        check("R8 open clamped to zero", int'(radio_on), 1);
        wait_until(60);
        check("R8 zero margin close-1", int'(rx_timeout), 0);
        wait_until(61);
        check("R8 zero margin close at 20", int'(rx_timeout), 1);

        // Close clamped to the last tick of the slot: open 535, close 599
        start_slot(590, 10, 100);
        wait_until(1605);
        check("R2 late window closed", int'(radio_on), 0);
        wait_until(1606);
        check("R2 late window open", int'(radio_on), 1);
        wait_until(1797);
        check("R8 clamp not yet timed out", int'(rx_timeout), 0);
        wait_until(1798);
        check("R8 clamp timeout at slot end", int'(rx_timeout), 1);

        // Reset in the middle of listening
        start_slot(100, 40, 60);
        wait_until(200);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-slot radio", int'(radio_on), 0);
        rst = 1'b0;
        @(negedge clk);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule